// File: doc/BRIEF.md
# Dual-Output Power-Up Sequencer

This block decides when each of two regulated outputs may begin its soft-start, and when each must be held off. It watches a supply-undervoltage status, two active-low enable requests, a ready flag from the internal bias regulator and a power-good flag per output. From these it drives an enable for that regulator, a one-cycle start command per channel and a level that holds each channel off.

A three-state strap, presented as a two-bit code, picks the operating mode once per power-up. In the two sequential modes one output is the master. The other output is the slave: it starts a fixed number of clock cycles after the master reports power-good, its own enable is ignored, and it is dropped together with the master. In independent mode each channel follows only its own enable. All analog thresholds are taken as already-resolved digital inputs. The block carries no data stream, so it has no valid/ready handshake; every pin is a plain control or status level.

Top module: `pwr_seq_top`

## Requirements
- R1: While `uvlo_ok` is low, from the next clock edge on `reg_en` is 0, `chan_off` is 2'b11 and `start_pls` is 2'b00.
- R2: With `uvlo_ok` high, `reg_en` is 1 when at least one enable input is low, and 0 (shutdown) when both are high; a channel is never running (its `chan_off` bit low) while `reg_en` is 0.
- R3: No channel starts while `reg_rdy` is low, even with its enable low.
- R4: `mode_pin` is captured in the first cycle that `uvlo_ok` is high after reset or after `uvlo_ok` was low: 2'b01 makes output 2 (index 1) the master, 2'b10 makes output 1 (index 0) the master, 2'b00 and 2'b11 select independent mode. Changes of `mode_pin` while `uvlo_ok` stays high have no effect.
- R5: In a sequential mode the slave leaves `chan_off` exactly SEQ_DELAY_CYC+1 clock edges after the first edge at which the running master's `pgood` bit is seen high, and not earlier.
- R6: In a sequential mode the slave's enable input is ignored: the slave starts from the master alone, and a low slave enable with the master disabled starts no channel.
- R7: In a sequential mode the slave is never running without the master; the master's enable going high turns both channels off on the same edge.
- R8: If the master's `pgood` drops before the delay expires, the delay count restarts from zero.
- R9: In independent mode each channel starts and stops only on its own enable; an enable that falls while the regulator is ready starts its channel on the third clock edge (two synchroniser stages plus the state register).
- R10: `start_pls[i]` is high for exactly one cycle, in the cycle in which channel i first leaves `chan_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_ok | input | 1 | Supply above undervoltage threshold |
| en1_n | input | 1 | Active-low enable request for output 1 (asynchronous) |
| en2_n | input | 1 | Active-low enable request for output 2 (asynchronous) |
| reg_rdy | input | 1 | Internal bias regulator output is up |
| mode_pin | input | 2 | Strap code: 01 high, 10 low, 00/11 floating |
| pgood | input | 2 | Per-output power-good (bit 0 = output 1) |
| reg_en | output | 1 | Turns on the internal bias regulator |
| start_pls | output | 2 | One-cycle start-soft-start command per channel |
| chan_off | output | 2 | Level holding each channel disabled |

## Verification
The assertions assume that `uvlo_ok`, `reg_rdy`, `mode_pin` and `pgood` are already synchronous to `clk`, and that `reg_rdy` only rises after `reg_en` has been driven. The bench changes every input one time unit after a rising edge, raises `reg_rdy` only after checking `reg_en`, and powers up through a low phase of `uvlo_ok` before each scenario so that every mode capture starts from a known state. The enables are the only inputs treated as asynchronous, and the latency checks count their two synchroniser stages.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_INDEP     = 2'd0,
    SEQ_ONE_FIRST = 2'd1,
    SEQ_TWO_FIRST = 2'd2
  } seq_mode_e;

  localparam logic [1:0] STRAP_HIGH = 2'b01;
  localparam logic [1:0] STRAP_LOW  = 2'b10;

  function automatic seq_mode_e strap_to_mode(input logic [1:0] strap);
    case (strap)
      STRAP_HIGH: strap_to_mode = SEQ_TWO_FIRST;
      STRAP_LOW:  strap_to_mode = SEQ_ONE_FIRST;
      default:    strap_to_mode = SEQ_INDEP;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_mode.sv
module pwr_seq_mode
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo_ok,
  input  logic [1:0] strap,
  output seq_mode_e  mode,
  output logic       mode_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= SEQ_INDEP;
      mode_vld <= 1'b0;
    end else if (!uvlo_ok) begin
      mode_vld <= 1'b0;
    end else if (!mode_vld) begin
      mode     <= strap_to_mode(strap);
      mode_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_delay.sv
module pwr_seq_delay #(
  parameter int CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pg,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!arm) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (!pg) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int SEQ_DELAY_CYC = 80000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo_ok,
  input  logic       en1_n,
  input  logic       en2_n,
  input  logic       reg_rdy,
  input  logic [1:0] mode_pin,
  input  logic [1:0] pgood,
  output logic       reg_en,
  output logic [1:0] start_pls,
  output logic [1:0] chan_off
);
  localparam int NCH = 2;

  logic [NCH-1:0] en_n_s;
  logic [NCH-1:0] en_req;
  logic [NCH-1:0] run_q;
  logic [NCH-1:0] run_nxt;
  seq_mode_e      mode_q;
  logic           mode_vld;
  logic           ready;
  logic           mst_idx;
  logic           dly_arm;
  logic           dly_done;

  pwr_seq_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({en2_n, en1_n}), .q(en_n_s)
  );
  assign en_req = ~en_n_s;

  pwr_seq_mode u_mode (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .strap(mode_pin),
    .mode(mode_q), .mode_vld(mode_vld)
  );

  assign ready   = uvlo_ok & reg_rdy & mode_vld;
  assign mst_idx = (mode_q == SEQ_TWO_FIRST);
  assign dly_arm = (mode_q != SEQ_INDEP) & run_q[mst_idx] & ready & en_req[mst_idx];

  pwr_seq_delay #(.CYCLES(SEQ_DELAY_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .arm(dly_arm), .pg(pgood[mst_idx]), .done(dly_done)
  );

  always_comb begin
    run_nxt = '0;
    case (mode_q)
      SEQ_ONE_FIRST: begin
        run_nxt[0] = ready & en_req[0];
        run_nxt[1] = run_nxt[0] & run_q[0] & dly_done;
      end
      SEQ_TWO_FIRST: begin
        run_nxt[1] = ready & en_req[1];
        run_nxt[0] = run_nxt[1] & run_q[1] & dly_done;
      end
      default: run_nxt = {NCH{ready}} & en_req;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_en <= 1'b0;
    else        reg_en <= uvlo_ok & (|en_req);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[c]     <= 1'b0;
        start_pls[c] <= 1'b0;
      end else begin
        run_q[c]     <= run_nxt[c];
        start_pls[c] <= run_nxt[c] & ~run_q[c];
      end
    end
    assign chan_off[c] = ~run_q[c];
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo_ok,
  input logic       reg_rdy,
  input logic [1:0] mode_q,
  input logic       mode_vld,
  input logic       reg_en,
  input logic [1:0] start_pls,
  input logic [1:0] chan_off
);
  p_uvlo_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!reg_en && chan_off == 2'b11 && start_pls == 2'b00));

  p_run_needs_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_off != 2'b11) |-> reg_en);

  p_rdy_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pls != 2'b00) |-> $past(reg_rdy && uvlo_ok));

  p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld && $past(mode_vld)) |-> $stable(mode_q));

  p_slave_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SEQ_ONE_FIRST && !chan_off[1]) |-> !chan_off[0]);

  p_slave_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SEQ_TWO_FIRST && !chan_off[0]) |-> !chan_off[1]);

  p_pulse_ch0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls[0] |=> !start_pls[0]);

  p_pulse_ch1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls[1] |=> !start_pls[1]);

  p_pulse_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pls & chan_off) == 2'b00);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .reg_rdy(reg_rdy),
  .mode_q(mode_q), .mode_vld(mode_vld), .reg_en(reg_en),
  .start_pls(start_pls), .chan_off(chan_off)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  localparam int DLY = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uvlo_ok = 1'b0;
  logic       en1_n = 1'b1;
  logic       en2_n = 1'b1;
  logic       reg_rdy = 1'b0;
  logic [1:0] mode_pin = 2'b00;
  logic [1:0] pgood = 2'b00;
  logic       reg_en;
  logic [1:0] start_pls;
  logic [1:0] chan_off;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(.SEQ_DELAY_CYC(DLY), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .en1_n(en1_n), .en2_n(en2_n),
    .reg_rdy(reg_rdy), .mode_pin(mode_pin), .pgood(pgood),
    .reg_en(reg_en), .start_pls(start_pls), .chan_off(chan_off)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pwr_up(input logic [1:0] strap);
    uvlo_ok = 1'b0; en1_n = 1'b1; en2_n = 1'b1; reg_rdy = 1'b0; pgood = 2'b00;
    step(4);
    mode_pin = strap;
    uvlo_ok = 1'b1;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1 reset reg_en", {7'd0, reg_en}, 8'd0);
    chk("R1 reset chan_off", {6'd0, chan_off}, 8'd3);
    chk("R1 reset start", {6'd0, start_pls}, 8'd0);
  endtask

  task automatic t_uvlo_low();
    uvlo_ok = 1'b0; en1_n = 1'b0; en2_n = 1'b0; reg_rdy = 1'b1;
    step(5);
    chk("R1 uvlo low reg_en", {7'd0, reg_en}, 8'd0);
    chk("R1 uvlo low chan_off", {6'd0, chan_off}, 8'd3);
  endtask

  task automatic t_indep();
    pwr_up(2'b00);
    en1_n = 1'b0;
    step(4);
    chk("R2 reg_en on one enable", {7'd0, reg_en}, 8'd1);
    chk("R3 no start before ready", {6'd0, chan_off}, 8'd3);
    reg_rdy = 1'b1;
    step(1);
    chk("R10 pulse ch0", {6'd0, start_pls}, 8'd1);
    step(1);
    chk("R10 pulse one cycle", {6'd0, start_pls}, 8'd0);
    chk("R9 ch0 running", {6'd0, chan_off}, 8'd2);
    en2_n = 1'b0;
    step(2);
    chk("R9 sync latency", {6'd0, chan_off}, 8'd2);
    step(1);
    chk("R9 ch1 third edge", {6'd0, chan_off}, 8'd0);
    en1_n = 1'b1;
    step(3);
    chk("R9 ch0 stops alone", {6'd0, chan_off}, 8'd1);
    en2_n = 1'b1;
    step(3);
    chk("R2 shutdown reg_en", {7'd0, reg_en}, 8'd0);
    chk("R2 shutdown chan_off", {6'd0, chan_off}, 8'd3);
  endtask

  task automatic t_seq_one();
    pwr_up(2'b10);
    en1_n = 1'b0;
    step(4);
    reg_rdy = 1'b1;
    step(2);
    chk("R5 master ch0 only", {6'd0, chan_off}, 8'd2);
    pgood[0] = 1'b1;
    step(DLY);
    chk("R5 slave not early", {6'd0, chan_off}, 8'd2);
    step(1);
    chk("R5 slave on time", {6'd0, chan_off}, 8'd0);
    chk("R10 slave pulse", {6'd0, start_pls}, 8'd2);
    chk("R6 slave enable high ignored", {7'd0, en2_n}, 8'd1);
    en1_n = 1'b1;
    step(3);
    chk("R7 master drop both off", {6'd0, chan_off}, 8'd3);
  endtask

  task automatic t_seq_two();
    pwr_up(2'b01);
    en1_n = 1'b0;
    step(4);
    reg_rdy = 1'b1;
    step(4);
    chk("R6 slave alone regulator on", {7'd0, reg_en}, 8'd1);
    chk("R6 slave alone no start", {6'd0, chan_off}, 8'd3);
    en2_n = 1'b0;
    step(3);
    chk("R5 master ch1 only", {6'd0, chan_off}, 8'd1);
    en1_n = 1'b1;
    pgood[1] = 1'b1;
    step(DLY - 3);
    pgood[1] = 1'b0;
    step(2);
    pgood[1] = 1'b1;
    step(DLY);
    chk("R8 restart no early start", {6'd0, chan_off}, 8'd1);
    step(1);
    chk("R8 start after full restart", {6'd0, chan_off}, 8'd0);
    uvlo_ok = 1'b0;
    step(1);
    chk("R1 uvlo drop chan_off", {6'd0, chan_off}, 8'd3);
    chk("R1 uvlo drop reg_en", {7'd0, reg_en}, 8'd0);
  endtask

  task automatic t_mode_frozen();
    pwr_up(2'b10);
    mode_pin = 2'b01;
    en2_n = 1'b0;
    step(4);
    reg_rdy = 1'b1;
    step(5);
    chk("R4 strap change ignored", {6'd0, chan_off}, 8'd3);
    pwr_up(2'b11);
    en2_n = 1'b0;
    step(4);
    reg_rdy = 1'b1;
    step(2);
    chk("R4 strap 11 independent", {6'd0, chan_off}, 8'd1);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_uvlo_low();
    t_indep();
    t_seq_one();
    t_seq_two();
    t_mode_frozen();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule